// File: doc/BRIEF.md
# Branch Condition and Target Unit

This unit resolves control transfers in a single combinational pass. It is given the four status flags left behind by the last arithmetic or compare operation (carry, zero, sign, overflow), a 4-bit condition selector, and the address of the instruction that follows the branch. From these it decides whether a conditional branch is taken. It also produces the address the front end should fetch next.

A conditional branch carries a short signed byte displacement. That displacement reaches from 128 bytes back to 127 bytes forward of the next-instruction address. An unconditional jump instead supplies a complete 32-bit destination, so any code address can be reached. The sixteen selector values form eight pairs. The odd member of each pair is the logical complement of the even member. Together the pairs cover both the signed and the unsigned orderings that a subtract-style compare can establish. No parity flag exists in this unit, so the parity pair sees a constant zero.

Top module: `branch_resolve_unit`

## Requirements
- R1: Selector 0 (overflow) is taken exactly when the overflow flag is 1; selector 1 is its complement.
- R2: Selector 2 (unsigned below) is taken exactly when the carry flag is 1; selector 3 is its complement.
- R3: Selector 4 (equal) is taken exactly when the zero flag is 1; selector 5 (not equal) is its complement.
- R4: Selector 6 (unsigned below-or-equal) is taken when carry OR zero is 1; selector 7 (unsigned above) is its complement.
- R5: Selector 8 (negative) is taken exactly when the sign flag is 1; selector 9 is its complement.
- R6: With parity tied to 0, selector 10 is never taken and selector 11 is always taken, for every flag value.
- R7: Selector 12 (signed less) is taken when sign XOR overflow is 1; selector 13 (signed greater-or-equal) is its complement.
- R8: Selector 14 (signed less-or-equal) is taken when zero OR (sign XOR overflow) is 1; selector 15 (signed greater) is its complement.
- R9: For a taken conditional branch, target equals next_pc plus the sign-extended 8-bit offset, modulo 2^32. Offsets range from -128 to +127.
- R10: When no transfer happens, target equals next_pc.
- R11: When jump_en is 1, taken is 1 and target equals jump_addr, whatever the flags, selector and offset are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| flag_carry | input | 1 | Carry / borrow flag |
| flag_zero | input | 1 | Zero-result flag |
| flag_sign | input | 1 | Sign-of-result flag |
| flag_ovf | input | 1 | Signed overflow flag |
| cond_sel | input | 4 | Condition selector; bit 0 inverts the pair's base test |
| jump_en | input | 1 | 1 selects an unconditional jump to jump_addr |
| next_pc | input | 32 | Address of the next sequential instruction |
| rel_off | input | 8 | Signed two's-complement branch displacement |
| jump_addr | input | 32 | Absolute jump destination |
| taken | output | 1 | Control transfer happens |
| target | output | 32 | Address to fetch next |

## Verification
Both taken and target are purely combinational, so each result is due zero cycles after its stimulus, in the same clock period. The bench applies every stimulus on a falling edge of its own clock. It then waits a quarter period before it compares the outputs, so the values it samples have settled and no clock edge comes between stimulus and check. Every combination of selector and flags gets its own stimulus and its own sampled check. So do the offset extremes, the address wrap cases and the jump cases.

// File: rtl/bcu_pkg.sv
package bcu_pkg;

  localparam int BCU_ADDR_W = 32;
  localparam int BCU_OFF_W  = 8;
  localparam int BCU_SEL_W  = 4;

  // Parity is not tracked by this unit; the parity pair sees this constant.
  localparam logic BCU_PARITY_TIE = 1'b0;

  typedef enum logic [BCU_SEL_W-1:0] {
    SEL_OVF  = 4'h0, SEL_NOVF = 4'h1,
    SEL_BLO  = 4'h2, SEL_AEQ  = 4'h3,
    SEL_EQ   = 4'h4, SEL_NEQ  = 4'h5,
    SEL_BLE  = 4'h6, SEL_ABV  = 4'h7,
    SEL_NEG  = 4'h8, SEL_POS  = 4'h9,
    SEL_PAR  = 4'hA, SEL_NPAR = 4'hB,
    SEL_LT   = 4'hC, SEL_GE   = 4'hD,
    SEL_LE   = 4'hE, SEL_GT   = 4'hF
  } cond_sel_e;

  typedef struct packed {
    logic cf;
    logic zf;
    logic sf;
    logic of;
  } flag_set_t;

endpackage

// File: rtl/bcu_cond_eval.sv
module bcu_cond_eval
  import bcu_pkg::*;
#(
  parameter int SEL_W = BCU_SEL_W
) (
  input  flag_set_t        flags,
  input  logic [SEL_W-1:0] sel,
  output logic             cond_true
);

  localparam int NUM_SEL  = 1 << SEL_W;
  localparam int NUM_BASE = NUM_SEL / 2;

  logic [NUM_BASE-1:0] base_test;
  logic [NUM_SEL-1:0]  sel_hit;
  logic                lt_signed;

  always_comb begin
    lt_signed    = flags.sf ^ flags.of;
    base_test    = '0;
    base_test[0] = flags.of;
    base_test[1] = flags.cf;
    base_test[2] = flags.zf;
    base_test[3] = flags.cf | flags.zf;
    base_test[4] = flags.sf;
    base_test[5] = BCU_PARITY_TIE;
    base_test[6] = lt_signed;
    base_test[7] = flags.zf | lt_signed;
  end

  // Each odd selector is the complement of its even partner.
  for (genvar c = 0; c < NUM_SEL; c++) begin : g_sel
    localparam logic INV = ((c % 2) == 1);
    assign sel_hit[c] = base_test[c/2] ^ INV;
  end

  assign cond_true = sel_hit[sel];

  always_comb begin
    if (sel == SEL_PAR)
      assert_parity_never_R6: assert (!cond_true)
        else $error("parity-set selector produced a taken result");
    if (sel == SEL_LT)
      assert_signed_lt_R7: assert (cond_true == (flags.sf != flags.of))
        else $error("signed-less result disagrees with sign/overflow");
    if (sel == SEL_BLO)
      assert_unsigned_below_R2: assert (cond_true == flags.cf)
        else $error("unsigned-below result disagrees with carry");
  end

endmodule

// File: rtl/bcu_target_gen.sv
module bcu_target_gen
  import bcu_pkg::*;
#(
  parameter int ADDR_W = BCU_ADDR_W,
  parameter int OFF_W  = BCU_OFF_W
) (
  input  logic [ADDR_W-1:0] next_pc,
  input  logic [OFF_W-1:0]  rel_off,
  input  logic [ADDR_W-1:0] jump_addr,
  input  logic              use_jump,
  input  logic              use_rel,
  output logic [ADDR_W-1:0] target
);

  localparam int EXT_W = ADDR_W - OFF_W;

  logic [ADDR_W-1:0] off_ext;
  logic [ADDR_W-1:0] rel_sum;

  always_comb begin
    off_ext = {{EXT_W{rel_off[OFF_W-1]}}, rel_off};
    rel_sum = next_pc + off_ext;   // wraps modulo 2^ADDR_W
    if (use_jump)
      target = jump_addr;
    else if (use_rel)
      target = rel_sum;
    else
      target = next_pc;
  end

endmodule

// File: rtl/branch_resolve_unit.sv
module branch_resolve_unit
  import bcu_pkg::*;
#(
  parameter int ADDR_W = BCU_ADDR_W,
  parameter int OFF_W  = BCU_OFF_W,
  parameter int SEL_W  = BCU_SEL_W
) (
  input  logic              flag_carry,
  input  logic              flag_zero,
  input  logic              flag_sign,
  input  logic              flag_ovf,
  input  logic [SEL_W-1:0]  cond_sel,
  input  logic              jump_en,
  input  logic [ADDR_W-1:0] next_pc,
  input  logic [OFF_W-1:0]  rel_off,
  input  logic [ADDR_W-1:0] jump_addr,
  output logic              taken,
  output logic [ADDR_W-1:0] target
);

  localparam int HI_W = ADDR_W - OFF_W + 1;

  flag_set_t         flags;
  logic              cond_true;
  logic              rel_go;
  logic [ADDR_W-1:0] delta;
  logic [HI_W-1:0]   delta_hi;

  assign flags = '{cf: flag_carry, zf: flag_zero, sf: flag_sign, of: flag_ovf};

  bcu_cond_eval #(.SEL_W(SEL_W)) u_cond (
    .flags     (flags),
    .sel       (cond_sel),
    .cond_true (cond_true)
  );

  assign rel_go = cond_true & ~jump_en;
  assign taken  = jump_en | cond_true;

  bcu_target_gen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_tgt (
    .next_pc   (next_pc),
    .rel_off   (rel_off),
    .jump_addr (jump_addr),
    .use_jump  (jump_en),
    .use_rel   (rel_go),
    .target    (target)
  );

  always_comb begin
    delta    = target - next_pc;
    delta_hi = delta[ADDR_W-1:OFF_W-1];
    if (jump_en)
      assert_jump_dest_R11: assert (taken && (target == jump_addr))
        else $error("jump did not go to the absolute destination");
    if (!taken)
      assert_fallthrough_R10: assert (target == next_pc)
        else $error("untaken transfer moved the fetch address");
    if (taken && !jump_en)
      assert_short_reach_R9: assert ((&delta_hi) || !(|delta_hi))
        else $error("relative target outside byte displacement reach");
  end

endmodule

// File: tb/tb_branch_resolve_unit.sv
module tb_branch_resolve_unit;

  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 20000;

  logic        clk;
  logic        rst_n;
  logic        flag_carry, flag_zero, flag_sign, flag_ovf;
  logic [3:0]  cond_sel;
  logic        jump_en;
  logic [31:0] next_pc, jump_addr, target;
  logic [7:0]  rel_off;
  logic        taken;

  int total = 0;
  int bad   = 0;
  int cycles = 0;

  branch_resolve_unit dut (
    .flag_carry(flag_carry), .flag_zero(flag_zero), .flag_sign(flag_sign),
    .flag_ovf(flag_ovf), .cond_sel(cond_sel), .jump_en(jump_en),
    .next_pc(next_pc), .rel_off(rel_off), .jump_addr(jump_addr),
    .taken(taken), .target(target)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG) begin
      bad   = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cycles, WATCHDOG);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic string req_of(int sel);
    case (sel / 2)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R5";
      5: return "R6";
      6: return "R7";
      default: return "R8";
    endcase
  endfunction

  function automatic logic ref_cond(int sel, logic cf, logic zf, logic sf, logic of);
    logic b;
    case (sel / 2)
      0: b = of;
      1: b = cf;
      2: b = zf;
      3: b = cf | zf;
      4: b = sf;
      5: b = 1'b0;
      6: b = sf ^ of;
      default: b = zf | (sf ^ of);
    endcase
    return b ^ (sel % 2 == 1);
  endfunction

  task automatic settle();
    #(CLK_PERIOD/4);
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic check(string req, logic exp_t, logic [31:0] exp_a);
    total++;
    if (taken !== exp_t || target !== exp_a) begin
      bad++;
      $display("FAIL %s: actual taken=%b target=%h expected taken=%b target=%h",
               req, taken, target, exp_t, exp_a);
    end
  endtask

  task automatic t_idle_state();
    // Reset-time inputs: selector 0, no flags; R1 not taken, R10 target = next_pc.
    settle();
    check("R10", 1'b0, 32'h0);
    step();
  endtask

  task automatic t_truth_table();
    jump_en   = 1'b0;
    next_pc   = 32'h0000_1000;
    rel_off   = 8'h10;
    for (int s = 0; s < 16; s++) begin
      for (int f = 0; f < 16; f++) begin
        logic e;
        cond_sel   = 4'(s);
        flag_carry = f[0]; flag_zero = f[1]; flag_sign = f[2]; flag_ovf = f[3];
        e = ref_cond(s, f[0], f[1], f[2], f[3]);
        settle();
        check(req_of(s), e, e ? 32'h0000_1010 : 32'h0000_1000);
        step();
      end
    end
  endtask

  task automatic t_offsets();
    // Selector 11 is always taken (R6), so the R9 address path is exercised.
    jump_en = 1'b0; cond_sel = 4'hB;
    flag_carry = 0; flag_zero = 0; flag_sign = 0; flag_ovf = 0;
    next_pc = 32'h0000_2000; rel_off = 8'h7F; settle(); check("R9", 1, 32'h0000_207F); step();
    rel_off = 8'h80; settle(); check("R9", 1, 32'h0000_1F80); step();
    rel_off = 8'hFF; settle(); check("R9", 1, 32'h0000_1FFF); step();
    rel_off = 8'h00; settle(); check("R9", 1, 32'h0000_2000); step();
    next_pc = 32'hFFFF_FFF0; rel_off = 8'h7F; settle(); check("R9", 1, 32'h0000_006F); step();
    next_pc = 32'h0000_0005; rel_off = 8'h80; settle(); check("R9", 1, 32'hFFFF_FF85); step();
  endtask

  task automatic t_not_taken();
    // Selector 10 never taken (R6); offset must not move the target (R10).
    jump_en = 1'b0; cond_sel = 4'hA;
    next_pc = 32'h8000_0000; rel_off = 8'h80; settle(); check("R10", 0, 32'h8000_0000); step();
    cond_sel = 4'h4; flag_zero = 0; rel_off = 8'h7F;
    next_pc = 32'hFFFF_FFFF; settle(); check("R10", 0, 32'hFFFF_FFFF); step();
  endtask

  task automatic t_jump();
    jump_en = 1'b1; next_pc = 32'h0000_4000; rel_off = 8'h44;
    jump_addr = 32'hDEAD_BEE0; cond_sel = 4'hA; settle(); check("R11", 1, 32'hDEAD_BEE0); step();
    jump_addr = 32'h0000_0000; cond_sel = 4'h4; flag_zero = 0; settle(); check("R11", 1, 32'h0); step();
    jump_addr = 32'hFFFF_FFFC; cond_sel = 4'hB; rel_off = 8'h80; settle(); check("R11", 1, 32'hFFFF_FFFC); step();
    jump_en = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0;
    flag_carry = 0; flag_zero = 0; flag_sign = 0; flag_ovf = 0;
    cond_sel = 4'h0; jump_en = 0; next_pc = '0; rel_off = '0; jump_addr = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    t_idle_state();
    t_truth_table();
    t_offsets();
    t_not_taken();
    t_jump();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule